// File: doc/BRIEF.md
# Coprocessor Operand Transfer Sequencer

This block takes one coprocessor primitive word that asks the main processor to move an operand between the coprocessor's operand register and an effective address location. It receives the primitive with a valid/ready handshake, together with the addressing-mode class of the current instruction and a flag saying whether that location can be written. It first checks whether the requested length and direction are legal for that mode. It then does one of three things: it reports a protocol violation, it finishes at once, or it issues a series of sized bus transfer commands. Each transfer command waits for the downstream ready.

Transfers use four-byte units while at least four bytes remain. What is left goes out as at most one two-byte and one one-byte transfer, in that order. For immediate operands the block also advances a scan pointer through the instruction stream. The pointer is loaded from a base input when a request is accepted.

The control is a five-state machine:
- IDLE accepts a request.
- CHECK decides legality.
- MOVE issues transfers.
- FINISH pulses done.
- REJECT pulses violation.

The transitions are:
- IDLE→CHECK on an accepted request.
- CHECK→REJECT on an illegal request.
- CHECK→FINISH on a zero length.
- CHECK→MOVE otherwise.
- MOVE→FINISH when the last transfer is accepted.
- FINISH→IDLE and REJECT→IDLE unconditionally.

Top module: `cp_operand_seq`

## Requirements
- R1: While reset (synchronous, active high) is asserted and in the cycle after it, the block is idle: `req_ready`=1, `xfer_valid`=0, `done_pulse`=0, `viol_pulse`=0, `scan_ptr`=0.
- R2: The operand length in bytes is `prim[7:0]` and the direction is `prim[15]`. Direction 0 moves data from the effective address to the operand register, and 1 moves it the other way. `xfer_dir` equals `prim[15]` on every transfer. The other primitive bits have no effect.
- R3: With `mode_class`=0 (register direct), only lengths 1, 2 and 4 are legal. Every other length, including 0, gives a violation.
- R4: With `mode_class`=1 (memory), every length from 0 to 255 is legal.
- R5: With `mode_class`=2 (immediate), the length must be 1 or even and the direction must be 0. Otherwise the request gives a violation.
- R6: Direction 1 with `ea_alterable`=0 gives a violation in every mode.
- R7: A legal nonzero length is moved as `floor(len/4)` transfers of size 4, then a transfer of size 2 if bit 1 of the length is set, then a transfer of size 1 if bit 0 is set. `xfer_size` carries the byte count as 1, 2 or 4.
- R8: A transfer is offered with `xfer_valid` and completes only in a cycle where `xfer_ready` is high. Until then its size and direction stay unchanged.
- R9: A legal zero-length request produces one `done_pulse` two cycles after acceptance and no transfers.
- R10: A violation is a one-cycle `viol_pulse` two cycles after acceptance, with no transfer issued. The block is ready for a new request in the following cycle.
- R11: `scan_ptr` loads `scan_base` when a request is accepted. For the immediate mode it advances by 2 on a completed 1-byte transfer and by the size on a 2- or 4-byte transfer. In all other cases it holds.
- R12: `mode_class`=3 is reserved and always gives a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Primitive request present |
| req_ready | output | 1 | Block can accept a request |
| prim | input | PRIM_W (16) | Primitive word; length in [7:0], direction in [15] |
| mode_class | input | 2 | 0 register direct, 1 memory, 2 immediate, 3 reserved |
| ea_alterable | input | 1 | Effective address may be written |
| scan_base | input | PTR_W (32) | Scan pointer start, loaded on acceptance |
| xfer_valid | output | 1 | Transfer command offered |
| xfer_ready | input | 1 | Downstream takes the transfer |
| xfer_size | output | 3 | Transfer size in bytes: 1, 2 or 4 |
| xfer_dir | output | 1 | Transfer direction, copy of the primitive's direction bit |
| done_pulse | output | 1 | One-cycle completion pulse |
| viol_pulse | output | 1 | One-cycle protocol violation pulse |
| scan_ptr | output | PTR_W (32) | Current scan pointer |

## Verification
The bench builds the block with its default parameters: an 8-bit length field, a 16-bit primitive with the direction at bit 15, and a 32-bit scan pointer. With these values the full length range up to 255 can be reached. A 255-byte memory transfer then runs 63 long-word units plus both remainder sizes while the downstream ready stalls every third cycle. The 32-bit pointer width lets the immediate-mode pointer steps be checked from bases well away from zero, including the odd step of 2 for a one-byte immediate.

// File: rtl/cp_operand_pkg.sv
package cp_operand_pkg;

    typedef enum logic [1:0] {
        MODE_REG  = 2'd0,
        MODE_MEM  = 2'd1,
        MODE_IMM  = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_MOVE,
        ST_FINISH,
        ST_REJECT
    } seq_state_e;

    localparam int unsigned SZ_W = 3;

endpackage

// File: rtl/cp_len_legal.sv
module cp_len_legal
    import cp_operand_pkg::*;
#(
    parameter int unsigned LEN_W = 8
) (
    input  logic [LEN_W-1:0] len,
    input  logic             dir_out,
    input  mode_e            mode,
    input  logic             alterable,
    output logic             illegal
);
    logic reg_ok;
    logic imm_ok;
    logic mode_ok;

    always_comb begin
        reg_ok = (len == LEN_W'(1)) || (len == LEN_W'(2)) || (len == LEN_W'(4));
        imm_ok = ((len == LEN_W'(1)) || !len[0]) && !dir_out;
        unique case (mode)
            MODE_REG:  mode_ok = reg_ok;
            MODE_MEM:  mode_ok = 1'b1;
            MODE_IMM:  mode_ok = imm_ok;
            MODE_RSVD: mode_ok = 1'b0;
            default:   mode_ok = 1'b0;
        endcase
        // writing to a location that cannot be written is refused in any mode
        illegal = !mode_ok || (dir_out && !alterable);
    end

endmodule

// File: rtl/cp_chunk_pick.sv
module cp_chunk_pick
    import cp_operand_pkg::*;
#(
    parameter int unsigned LEN_W = 8
) (
    input  logic [LEN_W-1:0] remain,
    output logic [SZ_W-1:0]  size,
    output logic             last
);
    always_comb begin
        if (remain >= LEN_W'(4)) begin
            size = SZ_W'(4);
        end else if (remain >= LEN_W'(2)) begin
            size = SZ_W'(2);
        end else begin
            size = SZ_W'(1);
        end
        last = (remain == LEN_W'(size));
    end

endmodule

// File: rtl/cp_scan_ptr.sv
module cp_scan_ptr
    import cp_operand_pkg::*;
#(
    parameter int unsigned PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] base,
    input  logic             step_en,
    input  logic [SZ_W-1:0]  size,
    output logic [PTR_W-1:0] ptr
);
    logic [PTR_W-1:0] step;

    always_comb begin
        // a one-byte immediate still occupies a whole 16-bit word
        step = (size == SZ_W'(1)) ? PTR_W'(2) : PTR_W'(size);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= base;
        end else if (step_en) begin
            ptr <= ptr + step;
        end
    end

endmodule

// File: rtl/cp_operand_seq.sv
module cp_operand_seq
    import cp_operand_pkg::*;
#(
    parameter int unsigned PRIM_W  = 16,
    parameter int unsigned LEN_W   = 8,
    parameter int unsigned DIR_BIT = 15,
    parameter int unsigned PTR_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PRIM_W-1:0] prim,
    input  logic [1:0]        mode_class,
    input  logic              ea_alterable,
    input  logic [PTR_W-1:0]  scan_base,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [2:0]        xfer_size,
    output logic              xfer_dir,
    output logic              done_pulse,
    output logic              viol_pulse,
    output logic [PTR_W-1:0]  scan_ptr
);
    seq_state_e state_q, state_d;

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] remain_q;
    logic             dir_q;
    mode_e            mode_q;
    logic             alt_q;

    logic             accept;
    logic             fire;
    logic             illegal;
    logic [SZ_W-1:0]  chunk;
    logic             chunk_last;

    assign accept = req_valid && req_ready;
    assign fire   = xfer_valid && xfer_ready;

    cp_len_legal #(.LEN_W(LEN_W)) legal_i (
        .len       (len_q),
        .dir_out   (dir_q),
        .mode      (mode_q),
        .alterable (alt_q),
        .illegal   (illegal)
    );

    cp_chunk_pick #(.LEN_W(LEN_W)) chunk_i (
        .remain (remain_q),
        .size   (chunk),
        .last   (chunk_last)
    );

    cp_scan_ptr #(.PTR_W(PTR_W)) scan_i (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .base    (scan_base),
        .step_en (fire && (mode_q == MODE_IMM)),
        .size    (chunk),
        .ptr     (scan_ptr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_CHECK;
            ST_CHECK: begin
                if (illegal) begin
                    state_d = ST_REJECT;
                end else if (len_q == '0) begin
                    state_d = ST_FINISH;
                end else begin
                    state_d = ST_MOVE;
                end
            end
            ST_MOVE:   if (fire && chunk_last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture and byte countdown
    always_ff @(posedge clk) begin
        if (rst) begin
            len_q    <= '0;
            remain_q <= '0;
            dir_q    <= 1'b0;
            mode_q   <= MODE_REG;
            alt_q    <= 1'b0;
        end else if (accept) begin
            len_q    <= prim[LEN_W-1:0];
            remain_q <= prim[LEN_W-1:0];
            dir_q    <= prim[DIR_BIT];
            mode_q   <= mode_e'(mode_class);
            alt_q    <= ea_alterable;
        end else if (fire) begin
            remain_q <= remain_q - LEN_W'(chunk);
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready  = 1'b0;
        xfer_valid = 1'b0;
        done_pulse = 1'b0;
        viol_pulse = 1'b0;
        xfer_size  = 3'd0;
        xfer_dir   = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_CHECK:  ;
            ST_MOVE: begin
                xfer_valid = 1'b1;
                xfer_size  = chunk;
                xfer_dir   = dir_q;
            end
            ST_FINISH: done_pulse = 1'b1;
            ST_REJECT: viol_pulse = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/cp_operand_seq_chk.sv
module cp_operand_seq_chk #(
    parameter int unsigned PTR_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             xfer_valid,
    input logic             xfer_ready,
    input logic [2:0]       xfer_size,
    input logic             xfer_dir,
    input logic             done_pulse,
    input logic             viol_pulse,
    input logic [PTR_W-1:0] scan_ptr
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (req_ready && !xfer_valid && !done_pulse && !viol_pulse && scan_ptr == '0));

    assert_size_legal_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (xfer_size == 3'd1 || xfer_size == 3'd2 || xfer_size == 3'd4));

    assert_hold_until_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_size) && $stable(xfer_dir)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> (!done_pulse && req_ready));

    assert_viol_single_R10: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |=> (!viol_pulse && req_ready));

    assert_viol_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $countones({viol_pulse, done_pulse, xfer_valid}) <= 1);

    assert_scan_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!(xfer_valid && xfer_ready) && !(req_valid && req_ready)) |=> $stable(scan_ptr));

endmodule

bind cp_operand_seq cp_operand_seq_chk #(.PTR_W(PTR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .xfer_valid (xfer_valid),
    .xfer_ready (xfer_ready),
    .xfer_size  (xfer_size),
    .xfer_dir   (xfer_dir),
    .done_pulse (done_pulse),
    .viol_pulse (viol_pulse),
    .scan_ptr   (scan_ptr)
);

// File: tb/cp_operand_seq_tb.sv
module cp_operand_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] prim = '0;
    logic [1:0]  mode_class = '0;
    logic        ea_alterable = 1'b0;
    logic [31:0] scan_base = '0;
    logic        xfer_valid;
    logic        xfer_ready = 1'b0;
    logic [2:0]  xfer_size;
    logic        xfer_dir;
    logic        done_pulse;
    logic        viol_pulse;
    logic [31:0] scan_ptr;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cp_operand_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .prim(prim), .mode_class(mode_class), .ea_alterable(ea_alterable),
        .scan_base(scan_base), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
        .xfer_size(xfer_size), .xfer_dir(xfer_dir), .done_pulse(done_pulse),
        .viol_pulse(viol_pulse), .scan_ptr(scan_ptr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // legality computed from the requirement text
    function automatic bit expect_bad(input int len, input bit dir, input int mode, input bit alt);
        bit bad;
        case (mode)
            0: bad = !(len == 1 || len == 2 || len == 4);           // R3
            1: bad = 1'b0;                                          // R4
            2: bad = !(len == 1 || (len % 2) == 0) || dir;          // R5
            default: bad = 1'b1;                                    // R12
        endcase
        if (dir && !alt) bad = 1'b1;                                // R6
        return bad;
    endfunction

    // one request, driven and observed; stall makes ready low every third cycle
    task automatic run_op(input string tag, input logic [15:0] p, input int mode,
                          input bit alt, input logic [31:0] base, input bit stall);
        int  len;
        bit  dir;
        bit  bad;
        int  remain;
        int  exp_sz;
        int  nx;
        int  cyc;
        int  wait_cyc;
        bit  got_done;
        bit  got_viol;
        logic [31:0] exp_ptr;
        len = int'(p[7:0]);
        dir = p[15];
        bad = expect_bad(len, dir, mode, alt);
        remain = len;
        exp_ptr = base;
        nx = 0;
        cyc = 0;
        wait_cyc = 0;
        got_done = 1'b0;
        got_viol = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, tag, "ready before request", req_ready, 1);
        req_valid = 1'b1;
        prim = p;
        mode_class = 2'(mode);
        ea_alterable = alt;
        scan_base = base;
        @(negedge clk);
        req_valid = 1'b0;
        prim = 16'hFFFF;
        scan_base = 32'hDEAD_BEEF;
        while (!got_done && !got_viol && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            xfer_ready = 1'b0;
            if (viol_pulse) got_viol = 1'b1;
            else if (done_pulse) got_done = 1'b1;
            else if (xfer_valid) begin
                exp_sz = (remain >= 4) ? 4 : (remain >= 2) ? 2 : 1;
                check(int'(xfer_size) == exp_sz, "R7", {tag, " size"}, xfer_size, exp_sz);
                check(xfer_dir == dir, "R2", {tag, " dir"}, xfer_dir, dir);
                if (!stall || (cyc % 3) != 0) begin
                    xfer_ready = 1'b1;
                    remain -= exp_sz;
                    if (mode == 2) exp_ptr += (exp_sz == 1) ? 2 : exp_sz;
                    nx++;
                end else begin
                    wait_cyc++;
                end
            end
        end
        xfer_ready = 1'b0;
        if (bad) begin
            check(got_viol, "R10", {tag, " violation"}, got_viol, 1);
            check(nx == 0, "R10", {tag, " no transfers"}, nx, 0);
            check(cyc == 1, "R10", {tag, " pulse timing"}, cyc, 1);
        end else begin
            check(got_done, "R7", {tag, " done"}, got_done, 1);
            check(remain == 0, "R7", {tag, " bytes moved"}, len - remain, len);
            if (len == 0) check(cyc == 1 && nx == 0, "R9", {tag, " zero length"}, nx, 0);
        end
        check(scan_ptr == exp_ptr, "R11", {tag, " scan ptr"}, scan_ptr, exp_ptr);
        @(negedge clk);
        check(!done_pulse && !viol_pulse && req_ready, "R10", {tag, " back to idle"},
              {done_pulse, viol_pulse, req_ready}, 1);
        if (stall && nx > 2) check(wait_cyc > 0, "R8", {tag, " stalls seen"}, wait_cyc, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready && !xfer_valid && !done_pulse && !viol_pulse && scan_ptr == 0,
              "R1", "reset idle", {req_ready, xfer_valid, done_pulse, viol_pulse}, 4'b1000);
    endtask

    task automatic t_register();
        run_op("R3 reg len1", 16'h8001, 0, 1'b1, 32'h100, 1'b0);
        run_op("R3 reg len2", 16'h0002, 0, 1'b0, 32'h100, 1'b0);
        run_op("R3 reg len4", 16'h0004, 0, 1'b0, 32'h100, 1'b1);
        run_op("R3 reg len3", 16'h0003, 0, 1'b1, 32'h100, 1'b0);
        run_op("R3 reg len0", 16'h0000, 0, 1'b1, 32'h100, 1'b0);
        run_op("R3 reg len8", 16'h0008, 0, 1'b1, 32'h100, 1'b0);
    endtask

    task automatic t_memory();
        run_op("R9 mem len0", 16'h0000, 1, 1'b1, 32'h200, 1'b0);
        run_op("R4 mem len7", 16'h0007, 1, 1'b0, 32'h200, 1'b0);
        run_op("R8 mem len255", 16'h00FF, 1, 1'b0, 32'h200, 1'b1);
        run_op("R4 mem len13 out", 16'h800D, 1, 1'b1, 32'h200, 1'b1);
        run_op("R2 mem noisy bits", 16'h7A05, 1, 1'b0, 32'h200, 1'b0);
    endtask

    task automatic t_immediate();
        run_op("R5 imm len1", 16'h0001, 2, 1'b0, 32'h1000, 1'b0);
        run_op("R5 imm len6", 16'h0006, 2, 1'b0, 32'h2000, 1'b1);
        run_op("R5 imm len254", 16'h00FE, 2, 1'b0, 32'h3000, 1'b0);
        run_op("R5 imm len5", 16'h0005, 2, 1'b1, 32'h4000, 1'b0);
        run_op("R5 imm dir out", 16'h8002, 2, 1'b1, 32'h5000, 1'b0);
    endtask

    task automatic t_misc();
        run_op("R6 mem write ro", 16'h8004, 1, 1'b0, 32'h300, 1'b0);
        run_op("R6 reg write ro", 16'h8002, 0, 1'b0, 32'h300, 1'b0);
        run_op("R12 reserved", 16'h0004, 3, 1'b1, 32'h300, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_register();
        t_memory();
        t_immediate();
        t_misc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule